// File: doc/BRIEF.md
# Management PHY Register Responder

This block stands in for the register set of a simple 10/100 Ethernet PHY as a MAC's management unit sees it. The host side drives a 16-bit address word (register index plus PHY address), a data word, a strobe that loads that data into the transmit-data holding register, and a command strobe carrying three command bits. The block keeps sixteen 16-bit registers and returns read data plus a link-fail flag. Serial bit timing on the management wire and auto-negotiation timing are not modelled: every command is a single-cycle register-level strobe.

The register set comes out of reset with a fixed image. Some registers refuse writes. A soft-reset bit in the control register reloads the whole image, and the bit is never stored. A link-up input is tracked so that the status register and the link-partner ability register follow the link. Only one PHY address answers. Reads to any other address return all ones, and writes to any other address are dropped.

Top module: `mgmt_phy_regs`

## Requirements
- R1: After reset, registers 0 to 5 read 0x1000, 0x7848, 0x2000, 0x5C90, 0x01E1 and 0x0000, registers 6 to 15 read 0, and `link_fail` is 0 (link input low).
- R2: When the link input rises, status bit 2 is set and 0x01E1 is ORed into register 5. When it falls, status bit 2 is cleared and register 5 is ANDed with 0x01FF. Either change takes effect at the first clock edge that sees the new input level.
- R3: A write to register 0 with bit 15 set reloads the full reset image of R1, with the current link level then applied as in R2, and stores nothing else. A write to register 0 with bit 15 clear stores the value.
- R4: Writes to registers 1, 2 and 3 leave them unchanged.
- R5: Registers 4 to 15 store the written value. Register indices 16 to 31 read as 0 and ignore writes.
- R6: The register index is `addr_word[12:8]` and the PHY address is `addr_word[4:0]`. Only PHY address 1 responds. A read to any other address returns 0xFFFF, and a write to any other address changes nothing.
- R7: Command bit 1 (read) loads `rd_data` and sets `link_fail` to the inverse of the link input. Command bit 2 writes the held transmit data to the addressed register.
- R8: Command bit 0 (scan) is held until the next command. While it is set, each link change updates `link_fail` at the same edge as R2. While it is clear, a link change leaves `link_fail` alone.
- R9: A `txd_we` strobe stores `wr_data` as the held transmit data and, when the PHY address is 1, writes it to the addressed register at once.
- R10: `rd_data` changes only on a read command and is valid one cycle after the strobe. When one command sets both bits 2 and 1, the read returns the value just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link level from the line side, 1 = up |
| addr_word | input | 16 | Register index in bits 12:8, PHY address in bits 4:0 |
| wr_data | input | 16 | Data for the transmit-data holding register |
| txd_we | input | 1 | Load `wr_data` and write it through to PHY 1 |
| cmd_we | input | 1 | Command strobe |
| cmd_val | input | 3 | Command bits: 2 = write, 1 = read, 0 = scan |
| rd_data | output | 16 | Data returned by the last read command |
| link_fail | output | 1 | Link-fail flag, 1 = link down |

## Verification
The bench builds the block with its defaults: 16-bit data, a 5-bit index, sixteen implemented registers and responder address 1. With these values the bench can sweep the whole 32-entry index space on the answering PHY and all 31 other PHY addresses. Every register value is predicted by a bench-side model of the write rules, the reset image and the link merge. The sweeps cover every write-protected index, every unimplemented index and every foreign address. Link toggles are run with scan on and with scan off, and a soft reset is issued while the link is up, so the merged image can be checked against arithmetic.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
   typedef logic [15:0] phy_word_t;

   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_STAT = 1;
   localparam int unsigned IDX_ID_HI = 2;
   localparam int unsigned IDX_ID_LO = 3;
   localparam int unsigned IDX_ADV = 4;
   localparam int unsigned IDX_PARTNER = 5;

   localparam phy_word_t PARTNER_UP_SET = 16'h01E1;
   localparam phy_word_t PARTNER_DN_KEEP = 16'h01FF;
   localparam int unsigned STAT_LINK_BIT = 2;
   localparam int unsigned CTRL_SRST_BIT = 15;

   // Power-on contents of each register, before the link level is merged in.
   function automatic phy_word_t boot_value(int unsigned idx);
      case (idx)
         IDX_CTRL:  return 16'h1000;
         IDX_STAT:  return 16'h7848;
         IDX_ID_HI: return 16'h2000;
         IDX_ID_LO: return 16'h5C90;
         IDX_ADV:   return 16'h01E1;
         default:   return 16'h0000;
      endcase
   endfunction

   // Fold the link level into the registers that report it.
   function automatic phy_word_t fold_link(int unsigned idx, phy_word_t v, logic up);
      phy_word_t r;
      r = v;
      if (idx == IDX_STAT) r[STAT_LINK_BIT] = up;
      else if (idx == IDX_PARTNER) r = up ? (v | PARTNER_UP_SET) : (v & PARTNER_DN_KEEP);
      return r;
   endfunction

   function automatic logic host_may_write(int unsigned idx);
      return !(idx == IDX_STAT || idx == IDX_ID_HI || idx == IDX_ID_LO);
   endfunction
endpackage

// File: rtl/mgmt_addr_decode.sv
module mgmt_addr_decode #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned RESP_ADDR = 1
) (
   input  logic [15:0]       addr_word,
   output logic [ADDR_W-1:0] reg_idx,
   output logic              phy_hit,
   output logic              reg_impl
);
   localparam int unsigned REG_LSB = 8;
   localparam logic [ADDR_W-1:0] RESP = ADDR_W'(RESP_ADDR);

   logic [ADDR_W-1:0] phy_sel;
   logic              unused_hi;

   assign reg_idx   = addr_word[REG_LSB +: ADDR_W];
   assign phy_sel   = addr_word[0 +: ADDR_W];
   assign phy_hit   = (phy_sel == RESP);
   assign unused_hi = ^addr_word;

   generate
      if (NUM_REGS >= (1 << ADDR_W)) begin : g_full
         assign reg_impl = 1'b1;
      end else begin : g_part
         localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);
         assign reg_impl = ({1'b0, reg_idx} < LIMIT);
      end
   endgenerate
endmodule

// File: rtl/mgmt_link_track.sv
module mgmt_link_track (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic rd_cmd,
   input  logic scan_load,
   input  logic scan_val,
   output logic link_chg,
   output logic link_fail
);
   logic link_q;
   logic scan_q;

   assign link_chg = (link_up != link_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q    <= 1'b0;
         scan_q    <= 1'b0;
         link_fail <= 1'b0;
      end else begin
         link_q <= link_up;
         if (scan_load) scan_q <= scan_val;
         if (rd_cmd || (scan_q && link_chg)) link_fail <= !link_up;
      end
   end
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
   import mgmt_phy_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  phy_word_t        wr_val,
   input  logic             link_up,
   input  logic             link_chg,
   input  logic [IDX_W-1:0] rd_idx,
   output phy_word_t        rd_val
);
   logic                         soft_rst;
   logic [NUM_REGS-1:0][15:0]    nxt_all;

   assign soft_rst = wr_en && (wr_idx == IDX_W'(IDX_CTRL)) && wr_val[CTRL_SRST_BIT];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam int unsigned SLOT = g;
      phy_word_t q;
      phy_word_t pre;
      phy_word_t nxt;
      logic      hit;

      assign hit = wr_en && (wr_idx == IDX_W'(g)) && host_may_write(SLOT);
      assign pre = hit ? wr_val : q;
      assign nxt = soft_rst ? fold_link(SLOT, boot_value(SLOT), link_up)
                 : link_chg ? fold_link(SLOT, pre, link_up)
                 : pre;
      assign nxt_all[g] = nxt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= boot_value(SLOT);
         else        q <= nxt;
      end
   end

   // Reads see the post-update value so a combined write-then-read returns new data.
   assign rd_val = nxt_all[rd_idx];
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
   import mgmt_phy_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned RESP_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic [15:0]       addr_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              txd_we,
   input  logic              cmd_we,
   input  logic [2:0]        cmd_val,
   output logic [DATA_W-1:0] rd_data,
   output logic              link_fail
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (DATA_W != 16) begin : g_bad_width
      $error("mgmt_phy_regs: DATA_W must be 16");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("mgmt_phy_regs: ADDR_W must be 1..8");
   end
   if (NUM_REGS < 8 || (1 << IDX_W) != NUM_REGS || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("mgmt_phy_regs: NUM_REGS must be a power of two in 8..2**ADDR_W");
   end
   if (RESP_ADDR >= (1 << ADDR_W)) begin : g_bad_resp
      $error("mgmt_phy_regs: RESP_ADDR out of range");
   end

   logic [ADDR_W-1:0] reg_idx;
   logic              phy_hit;
   logic              reg_impl;
   logic              rd_cmd;
   logic              wr_cmd;
   logic              wr_en;
   logic              link_chg;
   phy_word_t         txd_q;
   phy_word_t         wr_val;
   phy_word_t         rd_val;

   mgmt_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RESP_ADDR(RESP_ADDR)
   ) u_dec (
      .addr_word(addr_word), .reg_idx(reg_idx), .phy_hit(phy_hit), .reg_impl(reg_impl)
   );

   assign rd_cmd = cmd_we && cmd_val[1];
   assign wr_cmd = cmd_we && cmd_val[2];
   assign wr_en  = phy_hit && reg_impl && (txd_we || wr_cmd);
   assign wr_val = txd_we ? wr_data : txd_q;

   mgmt_link_track u_link (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .rd_cmd(rd_cmd),
      .scan_load(cmd_we), .scan_val(cmd_val[0]),
      .link_chg(link_chg), .link_fail(link_fail)
   );

   mgmt_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(reg_idx[IDX_W-1:0]),
      .wr_val(wr_val), .link_up(link_up), .link_chg(link_chg),
      .rd_idx(reg_idx[IDX_W-1:0]), .rd_val(rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd_q   <= '0;
         rd_data <= '0;
      end else begin
         if (txd_we) txd_q <= wr_data;
         if (rd_cmd) rd_data <= !phy_hit ? '1 : (reg_impl ? rd_val : '0);
      end
   end
endmodule

// File: rtl/mgmt_phy_regs_chk.sv
module mgmt_phy_regs_chk #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned RESP_ADDR = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        link_up,
   input logic [15:0] addr_word,
   input logic        cmd_we,
   input logic [2:0]  cmd_val,
   input logic [15:0] rd_data,
   input logic        link_fail,
   input logic        link_chg
);
   localparam logic [ADDR_W-1:0] RESP  = ADDR_W'(RESP_ADDR);
   localparam logic [ADDR_W:0]   LIMIT = (ADDR_W + 1)'(NUM_REGS);

   logic rd_cmd;
   logic own_phy;
   logic upper_idx;
   logic unused_chk;

   assign rd_cmd     = cmd_we && cmd_val[1];
   assign own_phy    = (addr_word[0 +: ADDR_W] == RESP);
   assign upper_idx  = ({1'b0, addr_word[8 +: ADDR_W]} >= LIMIT);
   assign unused_chk = ^{addr_word, cmd_val};

   p_foreign_ffff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd && !own_phy |=> rd_data == 16'hFFFF);

   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd && own_phy && upper_idx |=> rd_data == 16'h0000);

   p_read_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |=> link_fail == !$past(link_up));

   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cmd |=> $stable(rd_data));

   p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cmd && !link_chg |=> $stable(link_fail));
endmodule

bind mgmt_phy_regs mgmt_phy_regs_chk #(
   .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RESP_ADDR(RESP_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .link_up(link_up), .addr_word(addr_word),
   .cmd_we(cmd_we), .cmd_val(cmd_val), .rd_data(rd_data),
   .link_fail(link_fail), .link_chg(link_chg)
);

// File: tb/sim_mgmt_phy_regs.sv
module sim_mgmt_phy_regs;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        link_up;
   logic [15:0] addr_word;
   logic [15:0] wr_data;
   logic        txd_we;
   logic        cmd_we;
   logic [2:0]  cmd_val;
   logic [15:0] rd_data;
   logic        link_fail;

   always #5 clk = ~clk;

   mgmt_phy_regs u0 (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .addr_word(addr_word),
      .wr_data(wr_data), .txd_we(txd_we), .cmd_we(cmd_we), .cmd_val(cmd_val),
      .rd_data(rd_data), .link_fail(link_fail)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [15:0] m [16];
   logic        m_link;
   logic        m_scan;
   logic        m_lf;
   logic [15:0] m_txd;
   logic [15:0] m_rd;

   function automatic logic [15:0] boot(int i);
      case (i)
         0: return 16'h1000;
         1: return 16'h7848;
         2: return 16'h2000;
         3: return 16'h5C90;
         4: return 16'h01E1;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] merge(int i, logic [15:0] v, logic up);
      if (i == 1) return up ? (v | 16'h0004) : (v & 16'hFFFB);
      if (i == 5) return up ? (v | 16'h01E1) : (v & 16'h01FF);
      return v;
   endfunction

   task automatic model_reset(logic up);
      for (int i = 0; i < 16; i++) m[i] = merge(i, boot(i), up);
   endtask

   task automatic model_write(int phy, int r, logic [15:0] d);
      if (phy == 1 && r < 16) begin
         if (r == 0 && d[15]) model_reset(m_link);
         else if (r != 1 && r != 2 && r != 3) m[r] = d;
      end
   endtask

   task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic set_link(logic up, string tag);
      link_up = up;
      @(negedge clk);
      if (up != m_link) begin
         for (int i = 0; i < 16; i++) m[i] = merge(i, m[i], up);
         if (m_scan) m_lf = !up;
      end
      m_link = up;
      check(tag, {15'd0, link_fail}, {15'd0, m_lf});
   endtask

   task automatic wr_txd(int phy, int r, logic [15:0] d);
      addr_word = {3'd0, 5'(r), 3'd0, 5'(phy)};
      wr_data   = d;
      txd_we    = 1'b1;
      @(negedge clk);
      txd_we = 1'b0;
      m_txd  = d;
      model_write(phy, r, d);
   endtask

   task automatic issue(int phy, int r, logic [2:0] v, string tag);
      addr_word = {3'd0, 5'(r), 3'd0, 5'(phy)};
      cmd_val   = v;
      cmd_we    = 1'b1;
      @(negedge clk);
      cmd_we  = 1'b0;
      cmd_val = 3'b000;
      if (v[2]) model_write(phy, r, m_txd);
      m_scan = v[0];
      if (v[1]) begin
         m_rd = (phy != 1) ? 16'hFFFF : (r >= 16 ? 16'h0000 : m[r]);
         m_lf = !m_link;
      end
      check(tag, rd_data, m_rd);
      check(tag, {15'd0, link_fail}, {15'd0, m_lf});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; link_up = 1'b0; addr_word = '0; wr_data = '0;
      txd_we = 1'b0; cmd_we = 1'b0; cmd_val = 3'b000;
      m_link = 1'b0; m_scan = 1'b0; m_lf = 1'b0; m_txd = '0; m_rd = '0;
      model_reset(1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_data reset", rd_data, 16'h0000);
      check("R1 link_fail reset", {15'd0, link_fail}, 16'h0000);

      // R1 and R5: reset image and upper indices
      for (int r = 0; r < 32; r++) issue(1, r, 3'b010, "R1 reset image");

      // R4 and R5: write sweep over the whole index space
      for (int r = 0; r < 32; r++) wr_txd(1, r, 16'h1234 ^ 16'(r * 16'h0111));
      for (int r = 0; r < 32; r++) issue(1, r, 3'b010, "R4/R5 write rules");

      // R6: every foreign PHY address
      for (int p = 0; p < 32; p++) begin
         if (p != 1) begin
            wr_txd(p, 6, 16'hDEAD);
            issue(p, 6, 3'b010, "R6 foreign read");
         end
      end
      issue(1, 6, 3'b010, "R6 foreign write dropped");

      // R2: link merge in both directions
      wr_txd(1, 5, 16'hFE00);
      set_link(1'b1, "R2 up no scan");
      issue(1, 1, 3'b010, "R2 status up");
      issue(1, 5, 3'b010, "R2 partner up");
      set_link(1'b0, "R2 down no scan");
      issue(1, 1, 3'b010, "R2 status down");
      issue(1, 5, 3'b010, "R2 partner down");

      // R7 and R9: held data, command write
      wr_txd(4, 7, 16'h5A5A);
      issue(1, 7, 3'b010, "R9 foreign txd ignored");
      issue(1, 7, 3'b100, "R7 command write");
      issue(1, 7, 3'b010, "R7 command write result");
      wr_txd(9, 8, 16'h3C3C);
      issue(1, 8, 3'b110, "R10 write then read");

      // R8: scan on, then off
      issue(1, 0, 3'b001, "R8 scan on");
      set_link(1'b1, "R8 scan link up");
      set_link(1'b0, "R8 scan link down");
      set_link(1'b1, "R8 scan link up again");
      issue(1, 0, 3'b000, "R8 scan off");
      set_link(1'b0, "R8 no scan link down");
      issue(1, 0, 3'b010, "R7 read updates link_fail");
      set_link(1'b1, "R8 no scan link up");

      // R3: soft reset while link is up, then a plain control write
      wr_txd(1, 9, 16'h7777);
      wr_txd(1, 0, 16'h8000);
      for (int r = 0; r < 16; r++) issue(1, r, 3'b010, "R3 soft reset image");
      wr_txd(1, 0, 16'h0140);
      issue(1, 0, 3'b010, "R3 control store");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule